// File: doc/BRIEF.md
# SDRAM power-up initialization sequencer

This block sits on the controller side of a single-data-rate SDRAM interface and owns the command pins from reset until the memory is usable. After reset it holds the bus at no-operation for a programmable settling pause. It then precharges every bank and issues a programmable number of auto-refresh commands and one mode-register load. Finally it raises a ready flag that hands the pins to the normal traffic controller. Two legal orderings of the refresh group and the mode-register load are supported, and a parameter selects which one is used.

Every spacing is given in clock cycles through parameters, so the block can be retargeted by recomputing those counts from the clock period: the pause, the precharge-to-next-command gap, the refresh-to-refresh gap and the mode-load recovery gap. The defaults suit a 100 MHz clock: a 20000-cycle pause, 2 cycles after precharge, 7 cycles between refreshes, 2 cycles after the mode load, and eight refreshes. Clock enable is held high the whole time. A synchronous reset at any point restarts the whole sequence from the pause.

Top module: `sdram_powerup_seq`

## Requirements
- R1: From reset release, the bus carries NOP (chip select low; row strobe, column strobe and write enable high; address zero) for exactly PAUSE_CYC cycles, and the first command after that pause is precharge-all.
- R2: Precharge-all is encoded as chip select low, row strobe low, column strobe high, write enable low, address bit 10 high and all other address bits low. It is issued once per sequence.
- R3: Exactly REFRESH_N auto-refresh commands are issued, each encoded as chip select, row strobe and column strobe low with write enable high and address zero. Consecutive refreshes start exactly RFC_CYC cycles apart.
- R4: The mode-register load is issued once, encoded as chip select, row strobe, column strobe and write enable all low, with MODE_WORD on address bits 6..0 and address bits 11..7 low.
- R5: With MODE_FIRST = 0 the order is precharge, all refreshes, then mode load. With MODE_FIRST = 1 the order is precharge, mode load, then all refreshes.
- R6: The command that follows the precharge starts exactly PRECH_CYC cycles after it. The command that follows the mode load starts exactly MRD_CYC cycles after it.
- R7: Every command occupies the bus for one cycle. All other cycles carry NOP with address zero.
- R8: Clock enable is high in every cycle, including during reset.
- R9: init_done stays low until the recovery gap of the final command has run out: MRD_CYC cycles after the mode load in order 0, or RFC_CYC cycles after the last refresh in order 1. It then stays high and the bus stays at NOP.
- R10: Asserting reset at any point puts the bus at NOP and init_done low on the following cycle. After release, the full sequence repeats from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus; bit 10 marks precharge-all, bits 6..0 carry the mode word |
| init_done | output | 1 | High once initialization is complete |

## Verification
Two configurations are run cycle by cycle against a timeline computed in the bench. The first uses the default timings with refreshes ahead of the mode load. The second uses a short pause, unequal gaps, nine refreshes and the mode load first. Because every gap differs in that second configuration, a swapped gap, a wrong refresh count or a reversed order each shift a specific command to a cycle the model does not predict. Reset is also asserted at random points during the pause, the refresh run and after completion, which checks that the restart leaves nothing behind from the interrupted attempt.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int           ADDR_W     = 12,
  parameter int           PAUSE_CYC  = 20000,
  parameter int           PRECH_CYC  = 2,
  parameter int           RFC_CYC    = 7,
  parameter int           MRD_CYC    = 2,
  parameter int           REFRESH_N  = 8,
  parameter bit           MODE_FIRST = 1'b0,
  parameter logic [6:0]   MODE_WORD  = 7'b0100011
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);

  localparam int TMR_W = $clog2(PAUSE_CYC + PRECH_CYC + RFC_CYC + MRD_CYC + 1);
  localparam int REF_W = $clog2(REFRESH_N + 1);
  localparam logic [3:0] BUS_NOP = 4'b0111;
  localparam logic [3:0] BUS_PRE = 4'b0010;
  localparam logic [3:0] BUS_REF = 4'b0001;
  localparam logic [3:0] BUS_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PAUSE, S_PRE, S_REF, S_MRS, S_DONE} phase_t;

  phase_t            phase, nxt;
  logic [TMR_W-1:0]  tmr, gap;
  logic [REF_W-1:0]  refs;
  logic [3:0]        bus_q, bus_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, fire;

  assign fire = (phase != S_DONE) && (tmr == '0);

  always_comb begin
    nxt = S_DONE;
    case (phase)
      S_PAUSE: nxt = S_PRE;
      S_PRE:   nxt = MODE_FIRST ? S_MRS : S_REF;
      S_REF:   nxt = (refs < REFRESH_N[REF_W-1:0]) ? S_REF : (MODE_FIRST ? S_DONE : S_MRS);
      S_MRS:   nxt = MODE_FIRST ? S_REF : S_DONE;
      default: nxt = S_DONE;
    endcase
  end

  always_comb begin
    gap    = '0;
    bus_d  = BUS_NOP;
    addr_d = '0;
    case (nxt)
      S_PRE: begin gap = TMR_W'(PRECH_CYC - 1); bus_d = BUS_PRE; addr_d[10] = 1'b1; end
      S_REF: begin gap = TMR_W'(RFC_CYC - 1);   bus_d = BUS_REF; end
      S_MRS: begin gap = TMR_W'(MRD_CYC - 1);   bus_d = BUS_MRS; addr_d[6:0] = MODE_WORD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= S_PAUSE;
      tmr    <= TMR_W'(PAUSE_CYC - 1);
      refs   <= '0;
      bus_q  <= BUS_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (fire) begin
      phase  <= nxt;
      tmr    <= gap;
      if (nxt == S_REF) refs <= refs + 1'b1;
      bus_q  <= bus_d;
      addr_q <= addr_d;
      done_q <= (nxt == S_DONE);
    end else begin
      bus_q  <= BUS_NOP;
      addr_q <= '0;
      if (tmr != '0) tmr <= tmr - 1'b1;
    end
  end

  assign sd_cke    = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = bus_q;
  assign sd_addr   = addr_q;
  assign init_done = done_q;

  // observer of the pins for the spacing checks
  typedef enum logic [1:0] {K_NONE, K_PRE, K_REF, K_MRS} kind_t;
  logic             on_nop, on_pre, on_ref, on_mrs, on_cmd;
  kind_t            mon_last;
  logic [TMR_W-1:0] mon_since;

  assign on_nop = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == BUS_NOP);
  assign on_pre = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == BUS_PRE);
  assign on_ref = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == BUS_REF);
  assign on_mrs = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == BUS_MRS);
  assign on_cmd = on_pre || on_ref || on_mrs;

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_last  <= K_NONE;
      mon_since <= '0;
    end else begin
      if (on_cmd) begin
        mon_last  <= on_pre ? K_PRE : (on_ref ? K_REF : K_MRS);
        mon_since <= TMR_W'(1);
      end else if (mon_since != '1) begin
        mon_since <= mon_since + 1'b1;
      end
    end
  end

  p_pre_addr_r2: assert property (@(posedge clk) disable iff (rst)
    on_pre |-> (sd_addr == (ADDR_W'(1) << 10)));
  p_mrs_addr_r4: assert property (@(posedge clk) disable iff (rst)
    on_mrs |-> (sd_addr == ADDR_W'(MODE_WORD)));
  p_ref_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (on_ref && mon_last == K_REF) |-> (mon_since == TMR_W'(RFC_CYC)));
  p_after_pre_r6: assert property (@(posedge clk) disable iff (rst)
    (on_cmd && mon_last == K_PRE) |-> (mon_since == TMR_W'(PRECH_CYC)));
  p_after_mrs_r6: assert property (@(posedge clk) disable iff (rst)
    (on_cmd && mon_last == K_MRS) |-> (mon_since == TMR_W'(MRD_CYC)));
  p_only_legal_r7: assert property (@(posedge clk) disable iff (rst)
    on_nop || on_cmd);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (on_nop && sd_addr == '0));
  p_done_holds_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (on_nop && !init_done));

endmodule

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  localparam int AP = 20000, ATRP = 2, ATRC = 7, ATMRD = 2, AN = 8;
  localparam logic [6:0] AMODE = 7'h23;
  localparam int BP = 37, BTRP = 3, BTRC = 5, BTMRD = 4, BN = 9;
  localparam logic [6:0] BMODE = 7'h32;

  logic rst_a = 1'b1, rst_b = 1'b1;
  logic cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [11:0] addr_a, addr_b;

  sdram_powerup_seq uut (
    .clk(clk), .rst(rst_a), .sd_cke(cke_a), .sd_cs_n(cs_a), .sd_ras_n(ras_a),
    .sd_cas_n(cas_a), .sd_we_n(we_a), .sd_addr(addr_a), .init_done(done_a));

  sdram_powerup_seq #(.PAUSE_CYC(BP), .PRECH_CYC(BTRP), .RFC_CYC(BTRC), .MRD_CYC(BTMRD),
    .REFRESH_N(BN), .MODE_FIRST(1'b1), .MODE_WORD(BMODE)) uut_b (
    .clk(clk), .rst(rst_b), .sd_cke(cke_b), .sd_cs_n(cs_b), .sd_ras_n(ras_b),
    .sd_cas_n(cas_b), .sd_we_n(we_b), .sd_addr(addr_b), .init_done(done_b));

  int checks = 0, errors = 0, cyc = 0;

  // kinds: 0 NOP, 1 precharge, 2 refresh, 3 mode load, 4 deselect, 5 other
  function automatic int kind_of(logic cs, logic ras, logic cas, logic we);
    if (cs) return 4;
    case ({ras, cas, we})
      3'b111: return 0;
      3'b010: return 1;
      3'b001: return 2;
      3'b000: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_kind(int k, int p, int trp, int trc, int tmrd, int n, bit mf);
    int base, b2;
    if (k < p) return 0;
    if (k == p) return 1;
    base = p + trp;
    if (!mf) begin
      if (k >= base && k < base + n*trc && (k - base) % trc == 0) return 2;
      if (k == base + n*trc) return 3;
    end else begin
      if (k == base) return 3;
      b2 = base + tmrd;
      if (k >= b2 && k < b2 + n*trc && (k - b2) % trc == 0) return 2;
    end
    return 0;
  endfunction

  function automatic int done_at(int p, int trp, int trc, int tmrd, int n, bit mf);
    return mf ? p + trp + tmrd + n*trc : p + trp + n*trc + tmrd;
  endfunction

  function automatic logic [11:0] exp_addr(int kind, logic [6:0] mw);
    if (kind == 1) return 12'h400;
    if (kind == 3) return {5'b0, mw};
    return 12'h000;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic sample(bit w, output int kd, output int ad, output int ck, output int dn);
    if (w) begin kd = kind_of(cs_b, ras_b, cas_b, we_b); ad = addr_b; ck = cke_b; dn = done_b; end
    else   begin kd = kind_of(cs_a, ras_a, cas_a, we_a); ad = addr_a; ck = cke_a; dn = done_a; end
  endtask

  task automatic run(bit w, int abort);
    int p, trp, trc, tmrd, n, lim, kd, ad, ck, dn, ek, first_after;
    bit mf;
    logic [6:0] mw;
    string lbl;
    if (w) begin p = BP; trp = BTRP; trc = BTRC; tmrd = BTMRD; n = BN; mf = 1; mw = BMODE; end
    else   begin p = AP; trp = ATRP; trc = ATRC; tmrd = ATMRD; n = AN; mf = 0; mw = AMODE; end
    first_after = p + trp;
    lim = done_at(p, trp, trc, tmrd, n, mf) + 15;
    @(negedge clk);
    if (w) rst_b = 1'b1; else rst_a = 1'b1;
    repeat (3) @(negedge clk);
    sample(w, kd, ad, ck, dn);
    chk("R10 reset bus", kd, 0);
    chk("R10 reset done", dn, 0);
    chk("R8 cke in reset", ck, 1);
    if (w) rst_b = 1'b0; else rst_a = 1'b0;
    for (int k = 0; k <= lim; k++) begin
      if (k > 0) @(negedge clk);
      sample(w, kd, ad, ck, dn);
      ek = exp_kind(k, p, trp, trc, tmrd, n, mf);
      if (k == first_after)  lbl = "R5/R6 command after precharge";
      else if (ek == 1)      lbl = "R1/R2 precharge";
      else if (ek == 2)      lbl = "R3/R5 refresh";
      else if (ek == 3)      lbl = "R4/R5 mode load";
      else if (k < p)        lbl = "R1 pause";
      else                   lbl = "R7 idle";
      chk(lbl, kd, ek);
      chk(ek == 3 ? "R4 mode address" : (ek == 1 ? "R2 precharge address" : "R7 address"),
          ad, int'(exp_addr(ek, mw)));
      chk("R8 cke", ck, 1);
      chk("R9 ready", dn, int'(k >= done_at(p, trp, trc, tmrd, n, mf)));
      if (abort > 0 && k == abort) begin
        if (w) rst_b = 1'b1; else rst_a = 1'b1;
        @(negedge clk);
        sample(w, kd, ad, ck, dn);
        chk("R10 restart bus", kd, 0);
        chk("R10 restart done", dn, 0);
        return;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 200000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    run(1'b0, 0);
    for (int i = 0; i < 8; i++)
      run(1'b1, int'($urandom_range(5, done_at(BP, BTRP, BTRC, BTMRD, BN, 1'b1) + 8)));
    run(1'b1, 0);
    run(1'b0, int'($urandom_range(20001, 20060)));
    run(1'b1, BP - 1);
    run(1'b1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule